// File: doc/BRIEF.md
# Mobile SDRAM Power-Up Initialization Sequencer

This block takes a low-power SDR SDRAM from reset to a usable state. After reset it holds the clock enable high and drives no-operation commands for a programmable number of clocks, so the device sees a stable clock for its settling time. It then closes all banks with one precharge and issues a programmable number of auto refresh commands. It writes the normal mode register and, after that, the extended mode register that sets output driver strength and the partial-array self refresh region. Each command is followed by its own programmable gap, and a ready flag rises when the last gap has run out.

The contents of both mode registers come from input fields: CAS latency, burst type, burst length, single-bit write, drive strength and refresh region. The block places them at the address bit positions the memory decodes. A synchronous restart input and the asynchronous active-low reset both start the sequence again from the power-up wait. Periodic refresh and normal read or write traffic belong to the controller that takes over once ready is high.

Top module: `sdram_boot_seq`

## Requirements
- R1: While rst_n is low, the bus shows a no-operation command (cs_n=0, ras_n=1, cas_n=1, we_n=1), bank and address are all zero, cke is 1 and ready is 0.
- R2: Counting the first rising edge after reset release as edge 1, the first command is a precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0) at edge WAIT_CYC, with address bit 10 set, all other address bits 0 and bank 00.
- R3: Exactly NUM_REF auto refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) follow: the first TRP_CYC clocks after the precharge, each later one TRFC_CYC clocks after the previous.
- R4: A normal mode register write (all four strobes low, bank 00) comes TRFC_CYC clocks after the last refresh, with burst length on address 2..0, burst type on 3, CAS latency on 6..4, single-bit write on 9 and all other bits 0.
- R5: An extended mode register write (all four strobes low, bank 10) comes TMRD_CYC clocks after the normal one, with refresh region on address 2..0, drive strength on 6..5 and all other bits 0.
- R6: Ready rises TMRD_CYC clocks after the extended write, then stays high with the bus idle until reset or restart.
- R7: In every cycle that carries none of the commands above the bus shows a no-operation with bank and address zero, and cke stays 1 throughout.
- R8: restart sampled high at a rising edge clears ready and idles the bus at that edge; that edge then counts as edge 0 and the full sequence of R2 to R6 repeats from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of the whole sequence |
| cfg_cas_lat | input | 3 | CAS latency code for the normal register |
| cfg_burst_type | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_single_wr | input | 1 | Single-bit write enable |
| cfg_drive | input | 2 | Drive strength: 00 full, 01 half, 10 quarter, 11 eighth |
| cfg_region | input | 3 | Refreshed region: 000 full, 001 half, 010 quarter |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete |

## Verification
A stuck or skipped step counter shows up as a command appearing one or more clocks early or late, or a refresh count that is off by one, visible on the strobes at the very first misplaced command. A wrong field placement shows up at once on the address bus during the mode register write cycles, and a bad bank select separates the two register writes. A restart or ready fault is seen in the clock after restart is sampled or at the single edge where ready should rise.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_LMR = 4'b0000
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_EMRS,
    ST_DONE
  } boot_st_e;

  localparam logic [1:0] BA_NORMAL = 2'b00;
  localparam logic [1:0] BA_EXTEND = 2'b10;

endpackage

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q != {CNT_W{1'b1}}) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/boot_mode_words.sv
module boot_mode_words #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        cas_lat,
  input  logic              burst_type,
  input  logic [2:0]        burst_len,
  input  logic              single_wr,
  input  logic [1:0]        drive,
  input  logic [2:0]        region,
  output logic [ADDR_W-1:0] normal_word,
  output logic [ADDR_W-1:0] extend_word
);

  always_comb begin
    normal_word      = '0;
    normal_word[2:0] = burst_len;
    normal_word[3]   = burst_type;
    normal_word[6:4] = cas_lat;
    normal_word[9]   = single_wr;
  end

  always_comb begin
    extend_word      = '0;
    extend_word[2:0] = region;
    extend_word[6:5] = drive;
  end

endmodule

// File: rtl/boot_bus_drv.sv
module boot_bus_drv
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              issue,
  input  bus_cmd_e          cmd_d,
  input  logic [1:0]        ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              ready_set,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  logic [3:0]        cmd_q, cmd_n;
  logic [1:0]        ba_q, ba_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              rdy_q, rdy_n;
  logic              cke_q;

  always_comb begin
    cmd_n  = CMD_NOP;
    ba_n   = '0;
    addr_n = '0;
    rdy_n  = rdy_q;
    if (restart) begin
      rdy_n = 1'b0;
    end else begin
      if (issue) begin
        cmd_n  = cmd_d;
        ba_n   = ba_d;
        addr_n = addr_d;
      end
      if (ready_set) begin
        rdy_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      rdy_q  <= 1'b0;
      cke_q  <= 1'b1;
    end else begin
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
      rdy_q  <= rdy_n;
      cke_q  <= 1'b1;
    end
  end

  assign cke   = cke_q;
  assign cmd   = cmd_q;
  assign ba    = ba_q;
  assign addr  = addr_q;
  assign ready = rdy_q;

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int WAIT_CYC = 26667,
  parameter int NUM_REF  = 2,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 11,
  parameter int TMRD_CYC = 2,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_single_wr,
  input  logic [1:0]        cfg_drive,
  input  logic [2:0]        cfg_region,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int MAX_AB  = (WAIT_CYC > TRFC_CYC) ? WAIT_CYC : TRFC_CYC;
  localparam int MAX_CD  = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int MAX_LIM = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam int RC_W    = $clog2(NUM_REF + 1);

  localparam logic [CNT_W-1:0] END_WAIT = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] END_TRP  = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] END_TRFC = CNT_W'(TRFC_CYC - 1);
  localparam logic [CNT_W-1:0] END_TMRD = CNT_W'(TMRD_CYC - 1);
  localparam logic [RC_W-1:0]  REF_LAST = RC_W'(NUM_REF);

  boot_st_e          state_q, state_d;
  logic [RC_W-1:0]   ref_q, ref_d;
  logic [CNT_W-1:0]  gap_cnt;
  logic [CNT_W-1:0]  gap_end;
  logic              expired;
  logic              issue;
  logic              ready_set;
  bus_cmd_e          cmd_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] normal_word, extend_word;
  logic [ADDR_W-1:0] pre_word;
  logic [3:0]        bus_cmd;

  always_comb begin
    pre_word     = '0;
    pre_word[10] = 1'b1;
  end

  boot_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (issue || restart),
    .count (gap_cnt)
  );

  boot_mode_words #(.ADDR_W(ADDR_W)) u_words (
    .cas_lat     (cfg_cas_lat),
    .burst_type  (cfg_burst_type),
    .burst_len   (cfg_burst_len),
    .single_wr   (cfg_single_wr),
    .drive       (cfg_drive),
    .region      (cfg_region),
    .normal_word (normal_word),
    .extend_word (extend_word)
  );

  always_comb begin
    unique case (state_q)
      ST_WAIT: gap_end = END_WAIT;
      ST_PRE:  gap_end = END_TRP;
      ST_REF:  gap_end = END_TRFC;
      default: gap_end = END_TMRD;
    endcase
  end

  assign expired = (gap_cnt == gap_end);

  always_comb begin
    state_d   = state_q;
    ref_d     = ref_q;
    issue     = 1'b0;
    ready_set = 1'b0;
    cmd_d     = CMD_NOP;
    ba_d      = BA_NORMAL;
    addr_d    = '0;
    if (expired) begin
      unique case (state_q)
        ST_WAIT: begin
          issue   = 1'b1;
          cmd_d   = CMD_PRE;
          addr_d  = pre_word;
          state_d = ST_PRE;
        end
        ST_PRE: begin
          issue   = 1'b1;
          cmd_d   = CMD_REF;
          ref_d   = RC_W'(1);
          state_d = ST_REF;
        end
        ST_REF: begin
          issue = 1'b1;
          if (ref_q == REF_LAST) begin
            cmd_d   = CMD_LMR;
            ba_d    = BA_NORMAL;
            addr_d  = normal_word;
            state_d = ST_MRS;
          end else begin
            cmd_d = CMD_REF;
            ref_d = ref_q + 1'b1;
          end
        end
        ST_MRS: begin
          issue   = 1'b1;
          cmd_d   = CMD_LMR;
          ba_d    = BA_EXTEND;
          addr_d  = extend_word;
          state_d = ST_EMRS;
        end
        ST_EMRS: begin
          ready_set = 1'b1;
          state_d   = ST_DONE;
        end
        default: begin
          state_d = ST_DONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      ref_q   <= '0;
    end else if (restart) begin
      state_q <= ST_WAIT;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
    end
  end

  boot_bus_drv #(.ADDR_W(ADDR_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .issue     (issue),
    .cmd_d     (cmd_d),
    .ba_d      (ba_d),
    .addr_d    (addr_d),
    .ready_set (ready_set),
    .cke       (sd_cke),
    .cmd       (bus_cmd),
    .ba        (sd_ba),
    .addr      (sd_addr),
    .ready     (init_done)
  );

  assign sd_cs_n  = bus_cmd[3];
  assign sd_ras_n = bus_cmd[2];
  assign sd_cas_n = bus_cmd[1];
  assign sd_we_n  = bus_cmd[0];

endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 11,
  parameter int TMRD_CYC = 2,
  parameter int ADDR_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [1:0]        sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);

  logic [3:0] strobes;
  logic       see_nop, see_pre, see_ref, see_mrs, see_emrs, see_cmd;
  logic [2:0] last_q;   // 0 none, 1 pre, 2 ref, 3 mrs, 4 emrs
  logic [15:0] gap_q;

  assign strobes  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign see_nop  = (strobes == 4'b0111);
  assign see_pre  = (strobes == 4'b0010);
  assign see_ref  = (strobes == 4'b0001);
  assign see_mrs  = (strobes == 4'b0000) && (sd_ba == 2'b00);
  assign see_emrs = (strobes == 4'b0000) && (sd_ba == 2'b10);
  assign see_cmd  = !see_nop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 3'd0;
      gap_q  <= 16'd0;
    end else if (restart) begin
      last_q <= 3'd0;
      gap_q  <= 16'd0;
    end else begin
      if (see_cmd) begin
        gap_q <= 16'd1;
        if (see_pre)       last_q <= 3'd1;
        else if (see_ref)  last_q <= 3'd2;
        else if (see_mrs)  last_q <= 3'd3;
        else if (see_emrs) last_q <= 3'd4;
      end else if (gap_q != 16'hFFFF) begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n || restart)
    see_pre |-> (sd_addr[10] && sd_ba == 2'b00));

  p_ref_gap_r3: assert property (@(posedge clk) disable iff (!rst_n || restart)
    see_ref |-> ((last_q == 3'd1 && gap_q == 16'(TRP_CYC)) ||
                 (last_q == 3'd2 && gap_q == 16'(TRFC_CYC))));

  p_mrs_order_r4: assert property (@(posedge clk) disable iff (!rst_n || restart)
    see_mrs |-> (last_q == 3'd2 && gap_q == 16'(TRFC_CYC) &&
                 sd_addr[8:7] == 2'b00 && sd_addr[ADDR_W-1:10] == '0));

  p_emrs_order_r5: assert property (@(posedge clk) disable iff (!rst_n || restart)
    see_emrs |-> (last_q == 3'd3 && gap_q == 16'(TMRD_CYC) &&
                  sd_addr[4:3] == 2'b00 && sd_addr[ADDR_W-1:7] == '0));

  p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n || restart)
    $rose(init_done) |-> (last_q == 3'd4 && gap_q == 16'(TMRD_CYC)));

  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !restart) |=> init_done);

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (see_nop && sd_ba == 2'b00 && sd_addr == '0));

  p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!init_done && see_nop));

endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
  .TRP_CYC  (TRP_CYC),
  .TRFC_CYC (TRFC_CYC),
  .TMRD_CYC (TMRD_CYC),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .init_done (init_done)
);

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;

  localparam int W    = 24;
  localparam int NREF = 3;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int TMRD = 2;
  localparam int AW   = 12;

  localparam int PRE_C  = W;
  localparam int MRS_C  = W + TRP + NREF * TRFC;
  localparam int EMRS_C = MRS_C + TMRD;
  localparam int RDY_C  = EMRS_C + TMRD;
  localparam int END_C  = RDY_C + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          restart;
  logic [2:0]    cfg_cas_lat;
  logic          cfg_burst_type;
  logic [2:0]    cfg_burst_len;
  logic          cfg_single_wr;
  logic [1:0]    cfg_drive;
  logic [2:0]    cfg_region;
  logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]    sd_ba;
  logic [AW-1:0] sd_addr;
  logic          init_done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sdram_boot_seq #(
    .WAIT_CYC (W), .NUM_REF (NREF), .TRP_CYC (TRP),
    .TRFC_CYC (TRFC), .TMRD_CYC (TMRD), .ADDR_W (AW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .restart (restart),
    .cfg_cas_lat (cfg_cas_lat), .cfg_burst_type (cfg_burst_type),
    .cfg_burst_len (cfg_burst_len), .cfg_single_wr (cfg_single_wr),
    .cfg_drive (cfg_drive), .cfg_region (cfg_region),
    .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
    .sd_addr (sd_addr), .init_done (init_done)
  );

  function automatic logic [AW-1:0] exp_normal();
    return {2'b00, cfg_single_wr, 2'b00, cfg_cas_lat, cfg_burst_type, cfg_burst_len};
  endfunction

  function automatic logic [AW-1:0] exp_extend();
    return {5'b00000, cfg_drive, 2'b00, cfg_region};
  endfunction

  function automatic bit is_ref_cycle(int cyc);
    for (int i = 0; i < NREF; i++)
      if (cyc == W + TRP + i * TRFC) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] strobes();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pick_fields();
    int pick;
    cfg_cas_lat    = 3'(1 + $urandom % 3);
    cfg_burst_type = 1'($urandom % 2);
    pick = $urandom % 5;
    cfg_burst_len  = (pick == 4) ? 3'd7 : 3'(pick);
    cfg_single_wr  = 1'($urandom % 2);
    cfg_drive      = 2'($urandom % 4);
    cfg_region     = 3'($urandom % 3);
  endtask

  task automatic check_idle_reset();
    check(strobes() == 4'b0111 && sd_ba == 2'b00 && sd_addr == '0 && sd_cke && !init_done,
          "R1 reset state", {sd_cke, init_done, sd_ba, strobes()}, {1'b1, 1'b0, 2'b00, 4'b0111});
  endtask

  task automatic run_seq(input int upto);
    int idle_bad = 0;
    int rdy_bad  = 0;
    for (int cyc = 1; cyc <= upto; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc == PRE_C)
        check(strobes() == 4'b0010 && sd_ba == 2'b00 && sd_addr == 12'h400,
              "R2 precharge-all", {sd_ba, sd_addr, strobes()}, {2'b00, 12'h400, 4'b0010});
      else if (is_ref_cycle(cyc))
        check(strobes() == 4'b0001, "R3 refresh", strobes(), 4'b0001);
      else if (cyc == MRS_C)
        check(strobes() == 4'b0000 && sd_ba == 2'b00 && sd_addr == exp_normal(),
              "R4 normal register", {sd_ba, sd_addr, strobes()}, {2'b00, exp_normal(), 4'b0000});
      else if (cyc == EMRS_C)
        check(strobes() == 4'b0000 && sd_ba == 2'b10 && sd_addr == exp_extend(),
              "R5 extended register", {sd_ba, sd_addr, strobes()}, {2'b10, exp_extend(), 4'b0000});
      else if (strobes() != 4'b0111 || sd_ba != 2'b00 || sd_addr != '0)
        idle_bad++;
      if (sd_cke !== 1'b1) idle_bad++;
      if (init_done !== (cyc >= RDY_C)) rdy_bad++;
    end
    check(idle_bad == 0, "R7 idle cycles", idle_bad, 0);
    if (upto >= RDY_C)
      check(rdy_bad == 0, "R6 ready timing", rdy_bad, 0);
    else
      check(rdy_bad == 0 && !init_done, "R6 ready low mid-sequence", rdy_bad, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle_reset();
    @(negedge clk);
    check_idle_reset();
    rst_n = 1'b1;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    check(strobes() == 4'b0111 && !init_done, "R8 restart clears",
          {init_done, strobes()}, {1'b0, 4'b0111});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n   = 1'b0;
    restart = 1'b0;
    cfg_cas_lat = 3'd3; cfg_burst_type = 1'b0; cfg_burst_len = 3'd3;
    cfg_single_wr = 1'b1; cfg_drive = 2'b11; cfg_region = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle_reset();
    rst_n = 1'b1;
    run_seq(END_C);

    // random field sets, alternating reset and restart (R4, R5, R8)
    for (int k = 0; k < 6; k++) begin
      pick_fields();
      if (k % 2 == 0) do_restart();
      else do_reset();
      run_seq(END_C);
    end

    // directed: restart in the middle of the refresh train (R8)
    pick_fields();
    do_restart();
    run_seq(PRE_C + TRP + TRFC);
    do_restart();
    run_seq(END_C);

    // directed: asynchronous reset mid-wait (R1)
    do_restart();
    run_seq(W / 2);
    do_reset();
    run_seq(END_C);

    // directed: extreme field values (R4, R5)
    cfg_cas_lat = 3'd1; cfg_burst_type = 1'b1; cfg_burst_len = 3'd7;
    cfg_single_wr = 1'b0; cfg_drive = 2'b00; cfg_region = 3'b000;
    do_restart();
    run_seq(END_C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule